// File: doc/BRIEF.md
# Eleven-Floor Elevator Car Controller

This block keeps track of an elevator car in a building with a ground floor and ten upper floors, numbered 0 to 10. It holds the car's present floor and its destination floor in registers. It shows the present floor in two ways: an eleven-lamp one-hot indicator and a pair of seven-segment digits. It moves the car on request.

There are two ways to move the car:
- **Hall call.** A call from a floor switch moves the idle car straight to the calling floor. When several calls are active at once, the lowest floor wins.
- **Cabin trip.** The destination is set on a 4-bit binary selector, and the trip is released by raising the go switch and then lowering it. The car then walks one floor per step tick until it arrives, and the lamp and display follow every floor on the way.

All switch inputs are asynchronous and pass through a two-flop synchronizer. The step tick comes from an external slow-rate divider and is one clock wide. The block has no streaming data path. Every pin is a plain level-sensitive control or status signal with no handshake and no back-pressure.

Top module: `elev_car_ctrl`

## Requirements
- R1: The present floor and the destination floor are registers whose values always lie in 0..10.
- R2: A synchronous active-high reset puts the car at floor 0, lights lamp bit 0 only, shows 00 and clears the moving flag.
- R3: Exactly one bit of the lamp output is high at all times, and its index equals the present floor.
- R4: While the car is idle, active call switches move the car directly to the lowest-numbered active floor (bit i of the call input is floor i), with no intermediate floors.
- R5: Call switches have no effect while the moving flag is high. If a call and a go release are seen in the same cycle, the call is served and the trip is not started.
- R6: A trip starts when the synchronized go switch goes from 1 to 0. The destination is the 4-bit unsigned binary selector value captured at that moment (1010 is floor 10), and the moving flag rises.
- R7: A release with a selector value above 10, or equal to the present floor, is ignored: no trip starts and the car stays where it is.
- R8: While moving, each clock cycle with the tick high moves the car one floor toward the destination, either up or down. Cycles with the tick low leave the floor unchanged. The moving flag clears on the step that reaches the destination.
- R9: The two digit outputs show the present floor as tens and units in decimal. Each output is active-low with bit 6..0 = segments g..a. The lit-segment masks (active high) for digits 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F in hex, and the pins carry their complement.
- R10: Every switch input passes through two flip-flops. A switch change takes effect on the floor register at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_tick | input | 1 | One-cycle step enable from the slow divider |
| call_sw | input | 11 | Hall call switches, bit i = floor i |
| dest_sw | input | 4 | Destination floor, unsigned binary |
| go_sw | input | 1 | Trip release switch (acts on its falling edge) |
| floor_lamp | output | 11 | One-hot present-floor indicator |
| seg_tens | output | 7 | Tens digit, active-low, gfedcba |
| seg_units | output | 7 | Units digit, active-low, gfedcba |
| moving | output | 1 | High while a cabin trip is in progress |

## Verification
The bench uses the following directed and random cases to catch specific faults:
- **Simultaneous calls.** Calls on several floors at once check the priority. An arbiter scanning in the wrong direction would park the car on the highest caller.
- **Rejected destinations.** Selector values 11 to 15, and a destination equal to the present floor, must leave the car idle. A design that accepts them would start a trip that never terminates, or one that runs past floor 10.
- **Downward trips, idle ticks and arrival.** Downward trips, idle cycles between ticks, and arrival at floors 0 and 10 expose wrong step direction, steps taken without a tick, and a moving flag that clears one floor late.
- **Calls against trips.** Calls raised during a trip, and a call that coincides with the go release, expose a controller that lets hall calls override a trip in progress.

// File: rtl/elev_pkg.sv
package elev_pkg;

  // Lit-segment mask for a decimal digit, bit 6..0 = g..a, active high.
  function automatic logic [6:0] digit_mask(input logic [3:0] d);
    logic [6:0] m;
    case (d)
      4'd0: m = 7'b0111111;
      4'd1: m = 7'b0000110;
      4'd2: m = 7'b1011011;
      4'd3: m = 7'b1001111;
      4'd4: m = 7'b1100110;
      4'd5: m = 7'b1101101;
      4'd6: m = 7'b1111101;
      4'd7: m = 7'b0000111;
      4'd8: m = 7'b1111111;
      4'd9: m = 7'b1101111;
      default: m = 7'b1000000;
    endcase
    return m;
  endfunction

  // Active-low pin pattern.
  function automatic logic [6:0] digit_pins_n(input logic [3:0] d);
    return ~digit_mask(d);
  endfunction

  typedef enum logic [1:0] {
    CAR_IDLE = 2'd0,
    CAR_UP   = 2'd1,
    CAR_DOWN = 2'd2
  } car_mode_e;

endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/call_arbiter.sv
module call_arbiter #(
  parameter int NUM_FLOORS = 11,
  localparam int FW = $clog2(NUM_FLOORS)
) (
  input  logic [NUM_FLOORS-1:0] calls,
  output logic                  any_call,
  output logic [FW-1:0]         win_floor
);

  // Scan from the top down so the lowest active floor is written last.
  always_comb begin
    win_floor = '0;
    for (int i = NUM_FLOORS - 1; i >= 0; i--) begin
      if (calls[i]) win_floor = FW'(i);
    end
  end

  assign any_call = |calls;

endmodule

// File: rtl/car_core.sv
module car_core
  import elev_pkg::*;
#(
  parameter int NUM_FLOORS = 11,
  localparam int FW = $clog2(NUM_FLOORS),
  localparam logic [FW-1:0] TOP_FLOOR = FW'(NUM_FLOORS - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          call_valid,
  input  logic [FW-1:0] call_floor,
  input  logic          go_level,
  input  logic [FW-1:0] dest_code,
  output logic [FW-1:0] cur_floor,
  output logic [FW-1:0] dest_floor,
  output logic          moving
);

  car_mode_e     mode_q;
  logic          go_prev_q;
  logic          go_fall;
  logic          dest_ok;
  logic [FW-1:0] next_floor;

  assign go_fall    = go_prev_q & ~go_level;
  assign dest_ok    = (dest_code <= TOP_FLOOR) && (dest_code != cur_floor);
  assign next_floor = (mode_q == CAR_UP) ? cur_floor + FW'(1) : cur_floor - FW'(1);
  assign moving     = (mode_q != CAR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_floor  <= '0;
      dest_floor <= '0;
      mode_q     <= CAR_IDLE;
      go_prev_q  <= 1'b0;
    end else begin
      go_prev_q <= go_level;
      if (mode_q != CAR_IDLE) begin
        if (tick) begin
          cur_floor <= next_floor;
          if (next_floor == dest_floor) mode_q <= CAR_IDLE;
        end
      end else if (call_valid) begin
        cur_floor <= call_floor;
      end else if (go_fall && dest_ok) begin
        dest_floor <= dest_code;
        mode_q     <= (dest_code > cur_floor) ? CAR_UP : CAR_DOWN;
      end
    end
  end

endmodule

// File: rtl/floor_display.sv
module floor_display
  import elev_pkg::*;
#(
  parameter int NUM_FLOORS = 11,
  localparam int FW = $clog2(NUM_FLOORS)
) (
  input  logic [FW-1:0]         cur_floor,
  output logic [NUM_FLOORS-1:0] lamp,
  output logic [6:0]            seg_tens,
  output logic [6:0]            seg_units
);

  logic [FW-1:0] tens_val;
  logic [FW-1:0] units_val;

  for (genvar i = 0; i < NUM_FLOORS; i++) begin : g_lamp
    assign lamp[i] = (cur_floor == FW'(i));
  end

  assign tens_val  = cur_floor / FW'(10);
  assign units_val = cur_floor % FW'(10);
  assign seg_tens  = digit_pins_n(4'(tens_val));
  assign seg_units = digit_pins_n(4'(units_val));

endmodule

// File: rtl/elev_car_ctrl.sv
module elev_car_ctrl #(
  parameter int NUM_FLOORS  = 11,
  parameter int SYNC_STAGES = 2,
  localparam int FW = $clog2(NUM_FLOORS),
  localparam int SW = NUM_FLOORS + FW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_tick,
  input  logic [NUM_FLOORS-1:0] call_sw,
  input  logic [FW-1:0]         dest_sw,
  input  logic                  go_sw,
  output logic [NUM_FLOORS-1:0] floor_lamp,
  output logic [6:0]            seg_tens,
  output logic [6:0]            seg_units,
  output logic                  moving
);

  logic [SW-1:0]         sw_sync;
  logic [NUM_FLOORS-1:0] call_s;
  logic [FW-1:0]         dest_s;
  logic                  go_s;
  logic                  call_valid;
  logic [FW-1:0]         call_floor;
  logic [FW-1:0]         cur_floor;
  logic [FW-1:0]         dest_floor;

  sync_bits #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({go_sw, dest_sw, call_sw}),
    .dout (sw_sync)
  );

  assign call_s = sw_sync[NUM_FLOORS-1:0];
  assign dest_s = sw_sync[NUM_FLOORS +: FW];
  assign go_s   = sw_sync[SW-1];

  call_arbiter #(.NUM_FLOORS(NUM_FLOORS)) u_arb (
    .calls     (call_s),
    .any_call  (call_valid),
    .win_floor (call_floor)
  );

  car_core #(.NUM_FLOORS(NUM_FLOORS)) u_core (
    .clk        (clk),
    .rst        (rst),
    .tick       (step_tick),
    .call_valid (call_valid),
    .call_floor (call_floor),
    .go_level   (go_s),
    .dest_code  (dest_s),
    .cur_floor  (cur_floor),
    .dest_floor (dest_floor),
    .moving     (moving)
  );

  floor_display #(.NUM_FLOORS(NUM_FLOORS)) u_disp (
    .cur_floor (cur_floor),
    .lamp      (floor_lamp),
    .seg_tens  (seg_tens),
    .seg_units (seg_units)
  );

endmodule

// File: rtl/elev_car_checker.sv
module elev_car_checker #(
  parameter int NUM_FLOORS = 11,
  localparam int FW = $clog2(NUM_FLOORS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick,
  input logic                  moving,
  input logic [FW-1:0]         cur,
  input logic [FW-1:0]         dest,
  input logic [NUM_FLOORS-1:0] lamp
);

  assert_floor_range_R1: assert property (@(posedge clk) disable iff (rst)
    (cur <= FW'(NUM_FLOORS - 1)) && (dest <= FW'(NUM_FLOORS - 1)));

  assert_reset_home_R2: assert property (@(posedge clk)
    rst |=> (cur == '0) && !moving);

  assert_lamp_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    ($countones(lamp) == 1) && lamp[cur]);

  assert_trip_target_R7: assert property (@(posedge clk) disable iff (rst)
    moving |-> (dest != cur));

  assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (moving && !tick) |=> $stable(cur));

  assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
    (moving && tick) |=> ((cur == $past(cur) + FW'(1)) || (cur == $past(cur) - FW'(1))));

  assert_arrival_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(moving) |-> (cur == dest));

endmodule

bind elev_car_ctrl elev_car_checker #(.NUM_FLOORS(NUM_FLOORS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (step_tick),
  .moving (moving),
  .cur    (cur_floor),
  .dest   (dest_floor),
  .lamp   (floor_lamp)
);

// File: tb/tb_elev_car_ctrl.sv
module tb_elev_car_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_tick = 1'b0;
  logic [10:0] call_sw = '0;
  logic [3:0]  dest_sw = '0;
  logic        go_sw = 1'b0;
  logic [10:0] floor_lamp;
  logic [6:0]  seg_tens, seg_units;
  logic        moving;

  int vecs = 0;
  int errs = 0;
  int exp_cur = 0;
  bit exp_mov = 1'b0;

  always #10 clk = ~clk;

  elev_car_ctrl dut (
    .clk(clk), .rst(rst), .step_tick(step_tick), .call_sw(call_sw),
    .dest_sw(dest_sw), .go_sw(go_sw), .floor_lamp(floor_lamp),
    .seg_tens(seg_tens), .seg_units(seg_units), .moving(moving)
  );

  function automatic logic [6:0] ref_seg(input int d);
    logic [6:0] m;
    case (d)
      0: m = 7'h3F; 1: m = 7'h06; 2: m = 7'h5B; 3: m = 7'h4F; 4: m = 7'h66;
      5: m = 7'h6D; 6: m = 7'h7D; 7: m = 7'h07; 8: m = 7'h7F; default: m = 7'h6F;
    endcase
    return ~m;
  endfunction

  function automatic int lowest_call(input logic [10:0] m);
    for (int i = 0; i < 11; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic cmp(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    cmp({req, " lamp R3"}, int'(floor_lamp), 1 << exp_cur);
    cmp({req, " tens R9"}, int'(seg_tens), int'(ref_seg(exp_cur / 10)));
    cmp({req, " units R9"}, int'(seg_units), int'(ref_seg(exp_cur % 10)));
    cmp({req, " moving"}, int'(moving), int'(exp_mov));
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_call(input logic [10:0] m);
    call_sw = m;
    cycles(4);
    if (!exp_mov && m != 0) exp_cur = lowest_call(m);
    check_state("R4 call");
    call_sw = '0;
    cycles(4);
  endtask

  // Press and release go; returns whether a trip is expected.
  task automatic release_go(input int d, output bit started);
    dest_sw = 4'(d);
    go_sw = 1'b1;
    cycles(4);
    go_sw = 1'b0;
    cycles(4);
    started = (d <= 10) && (d != exp_cur);
    if (started) exp_mov = 1'b1;
    check_state(started ? "R6 start" : "R7 reject");
  endtask

  task automatic run_steps(input int d, input bit gaps);
    while (exp_mov) begin
      if (gaps && ($urandom % 3 == 0)) begin
        cycles(2);
        check_state("R8 no tick");
      end
      step_tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      step_tick = 1'b0;
      exp_cur = (d > exp_cur) ? exp_cur + 1 : exp_cur - 1;
      if (exp_cur == d) exp_mov = 1'b0;
      check_state("R8 step");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    bit st;
    void'($urandom(32'd2024));
    cycles(3);
    rst = 1'b0;
    cycles(1);
    check_state("R2 reset");

    // R10: a call is not visible after two edges, visible after three
    @(negedge clk);
    call_sw = 11'b000_0010_0000;
    cycles(2);
    check_state("R10 latency early");
    @(posedge clk); @(negedge clk);
    exp_cur = 5;
    check_state("R10 latency");
    call_sw = '0;
    cycles(4);

    do_call(11'b100_0010_1000);               // R4 lowest of 3,5,10 -> 3
    do_call(11'b100_0000_0000);               // R4 floor 10 alone
    release_go(10, st);                       // R7 destination equals present floor
    release_go(13, st);                       // R7 out of range
    release_go(0, st);  run_steps(0, 1'b1);   // R8 downward to ground
    release_go(10, st);                       // R6 binary 1010
    call_sw = 11'b000_0000_0001;              // R5 call while moving
    cycles(5);
    check_state("R5 ignored");
    call_sw = '0;
    cycles(4);
    run_steps(10, 1'b1);

    // R5 call and go release together: call wins
    dest_sw = 4'd2; go_sw = 1'b1; cycles(4);
    go_sw = 1'b0; call_sw = 11'b000_0100_0000;
    cycles(4);
    exp_cur = 6;
    check_state("R5 call beats go");
    call_sw = '0;
    cycles(4);
    check_state("R5 no trip");

    for (int it = 0; it < 60; it++) begin
      if ($urandom % 2 == 0) begin
        logic [10:0] m;
        m = 11'($urandom);
        if ($urandom % 2 == 0) m = 11'(1) << ($urandom % 11);
        do_call(m);
      end else begin
        int d;
        d = int'($urandom % 16);
        release_go(d, st);
        if (st) run_steps(d, 1'b1);
      end
    end

    rst = 1'b1; cycles(1); rst = 1'b0;
    exp_cur = 0; exp_mov = 1'b0;
    check_state("R2 reset again");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule